// File: doc/BRIEF.md
# Interrupt Source Conditioning Unit

This block sits in front of the priority and masking logic of an interrupt controller and turns raw request lines into clean pending bits. A 32-bit source vector is split into external pins (bits 3:0), internal peripheral sources (bits 18:4) and reserved positions (bits 31:19). Each internal source goes through a two-flop synchronizer clocked by the controller clock, unless its bypass bit is set. After that, a trigger detector selects edge or level behaviour for the source.

Each external pin is always synchronized. It then has a 3-bit mode field that chooses falling, rising or both-edge detection, or low or high level detection. The same field also turns on a noise filter. The filter accepts a new pin value only after three equal consecutive samples.

Software-side logic writes three configuration registers through simple write-enable ports and reads them back. It clears edge-captured pending bits through a write-one-to-clear port. A level-captured pending bit tracks its conditioned input.

Top module: `irq_source_conditioner`

## Requirements
- R1: After reset, every pending bit is 0, all trigger bits read 0 (edge), all bypass bits read 0 (synchronized), and every pin mode field reads 000.
- R2: An internal source with bypass bit 0 sets its edge pending bit three clock edges after the raw rise is first sampled. With bypass bit 1, it sets the bit at the first edge that samples the rise.
- R3: An internal source with trigger bit 0 captures a rising edge into a pending bit that stays set after the input falls. With trigger bit 1, the pending bit follows the conditioned input.
- R4: A write on the clear port with a 1 in bit i clears edge pending bit i at that edge. Bits written 0 are unaffected. An edge detected at the same edge keeps the bit set.
- R5: Trigger and bypass registers store only bits 18:4. Bits 3:0 and 31:19 of those registers read 0. Pending bits 31:19 are always 0, whatever the raw inputs are.
- R6: Pin mode low bits select the edge: 00 falling, 01 rising, 10 both. Bit 2 of the code is 0 for filtered and 1 for unfiltered.
- R7: With the filter on, pin pulses of one or two cycles leave the pending bit unchanged, and a pulse held for three cycles is accepted. With the filter off, a one- or two-cycle pulse is captured.
- R8: Mode 011 gives a low-level pending bit and mode 111 gives a high-level pending bit, both filtered.
- R9: A level-mode pending bit ignores the clear port.
- R10: The mode of pin n sits in bits 3n+2:3n of the pin mode register. Writing that register changes only the pins it encodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_raw | input | 32 | Raw request lines (pins 3:0, internal 18:4) |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 32 | Trigger bits, 0 edge, 1 level |
| sync_we | input | 1 | Bypass register write strobe |
| sync_wdata | input | 32 | Bypass bits, 0 synchronized, 1 bypassed |
| pmode_we | input | 1 | Pin mode register write strobe |
| pmode_wdata | input | 12 | Four 3-bit pin mode codes |
| clr_we | input | 1 | Clear strobe |
| clr_wdata | input | 32 | Write-one-to-clear mask |
| trig_rd | output | 32 | Trigger register readback |
| sync_rd | output | 32 | Bypass register readback |
| pmode_rd | output | 12 | Pin mode register readback |
| pending | output | 32 | Pending bit per source |

## Verification
The synchronizer latency assertion assumes the bypass bit has been steady for two cycles before it compares the output with the input. The bench only changes the bypass register while the raw lines are quiet. The filter assertion assumes the raw value seen by the filter is the only thing that can move its output. The bench drives pins only at falling clock edges and never toggles them while a mode write is in flight. The clear and level-follow properties assume the trigger selection stays fixed across the cycle being checked. The bench keeps each mode fixed for many cycles around every pulse and clear.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int MODE_W = 3;

  typedef logic [MODE_W-1:0] pin_mode_t;

  // Low two bits equal to 11 select level detection.
  function automatic logic mode_is_level(pin_mode_t m);
    return m[1:0] == 2'b11;
  endfunction

  // Filter is used for all codes with bit 2 low, and for high-level 111.
  function automatic logic mode_filter_on(pin_mode_t m);
    return (m[2] == 1'b0) || (m == 3'b111);
  endfunction

  function automatic logic mode_rise(pin_mode_t m);
    return (m[1:0] == 2'b01) || (m[1:0] == 2'b10);
  endfunction

  function automatic logic mode_fall(pin_mode_t m);
    return (m[1:0] == 2'b00) || (m[1:0] == 2'b10);
  endfunction

  // For level codes, bit 2 picks the active polarity.
  function automatic logic mode_level_high(pin_mode_t m);
    return m[2];
  endfunction

endpackage

// File: rtl/irq_sync_stage.sv
module irq_sync_stage #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic bypass,
  output logic dout
);

  logic [STAGES-1:0] chain_q;
  logic              sync_tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign sync_tap = chain_q[STAGES-1];
  assign dout     = bypass ? din : sync_tap;

  // Edges seen since reset, saturating, so that history checks start clean.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !bypass && !$past(bypass) && !$past(bypass, 2))
          |-> (dout == $past(din, 2)));
    end
  endgenerate

endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic enable,
  output logic dout
);

  localparam int RW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] hist_q;
  logic             filt_q;
  logic             all_same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[DEPTH-2:0], din};
  end

  assign all_same = (&hist_q) | (~|hist_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        filt_q <= 1'b0;
    else if (all_same) filt_q <= hist_q[0];
  end

  assign dout = enable ? filt_q : din;

  // Independent run-length tracker of the raw input for the checker.
  logic          last_in_q;
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_in_q <= 1'b0;
      run_q     <= '0;
    end else begin
      last_in_q <= din;
      if (din != last_in_q)          run_q <= '0;
      else if (run_q != RW'(DEPTH))  run_q <= run_q + 1'b1;
    end
  end

  assert_filter_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q))
      |-> (($past(run_q) >= RW'(DEPTH - 1)) && ($past(last_in_q) == filt_q)));

endmodule

// File: rtl/irq_trigger_cell.sv
module irq_trigger_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic level_sel,
  input  logic rise_en,
  input  logic fall_en,
  input  logic level_high,
  input  logic clr,
  output logic pend
);

  logic prev_q;
  logic pend_q;
  logic edge_hit;
  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  assign edge_hit = (rise_en & cond & ~prev_q) | (fall_en & ~cond & prev_q);
  assign active   = level_high ? cond : ~cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (level_sel) pend_q <= active;
    else                pend_q <= edge_hit | (pend_q & ~clr);
  end

  assign pend = pend_q;

  assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(level_sel) && $past(pend) && !$past(clr)) |-> pend);

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(level_sel) && $past(clr) && !$past(edge_hit)) |-> !pend);

  assert_edge_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(level_sel) && $past(edge_hit)) |-> pend);

  assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(level_sel) |-> (pend == $past(active)));

endmodule

// File: rtl/irq_source_conditioner.sv
module irq_source_conditioner
  import irq_cond_pkg::*;
#(
  parameter int SRC_W      = 32,
  parameter int EXT_N      = 4,
  parameter int INT_N      = 15,
  parameter int SYNC_DEPTH = 2,
  parameter int FILT_DEPTH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SRC_W-1:0]        src_raw,
  input  logic                    trig_we,
  input  logic [SRC_W-1:0]        trig_wdata,
  input  logic                    sync_we,
  input  logic [SRC_W-1:0]        sync_wdata,
  input  logic                    pmode_we,
  input  logic [EXT_N*MODE_W-1:0] pmode_wdata,
  input  logic                    clr_we,
  input  logic [SRC_W-1:0]        clr_wdata,
  output logic [SRC_W-1:0]        trig_rd,
  output logic [SRC_W-1:0]        sync_rd,
  output logic [EXT_N*MODE_W-1:0] pmode_rd,
  output logic [SRC_W-1:0]        pending
);

  localparam int INT_LO = EXT_N;
  localparam int INT_HI = EXT_N + INT_N - 1;
  localparam int USED   = EXT_N + INT_N;

  // Configuration registers
  logic [INT_N-1:0]        trig_q;
  logic [INT_N-1:0]        byp_q;
  logic [EXT_N*MODE_W-1:0] pmode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= '0;
      byp_q   <= '0;
      pmode_q <= '0;
    end else begin
      if (trig_we)  trig_q  <= trig_wdata[INT_HI:INT_LO];
      if (sync_we)  byp_q   <= sync_wdata[INT_HI:INT_LO];
      if (pmode_we) pmode_q <= pmode_wdata;
    end
  end

  logic [SRC_W-1:0] clr_vec;
  assign clr_vec = clr_we ? clr_wdata : '0;

  logic [USED-1:0] pend_used;

  // External pins: always synchronized, then filter, then mode decode.
  generate
    for (genvar p = 0; p < EXT_N; p++) begin : g_pin
      pin_mode_t mode;
      logic      synced;
      logic      cond;

      assign mode = pmode_q[p*MODE_W +: MODE_W];

      irq_sync_stage #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (src_raw[p]),
        .bypass (1'b0),
        .dout   (synced)
      );

      irq_glitch_filter #(.DEPTH(FILT_DEPTH)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (synced),
        .enable (mode_filter_on(mode)),
        .dout   (cond)
      );

      irq_trigger_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond       (cond),
        .level_sel  (mode_is_level(mode)),
        .rise_en    (mode_rise(mode)),
        .fall_en    (mode_fall(mode)),
        .level_high (mode_level_high(mode)),
        .clr        (clr_vec[p]),
        .pend       (pend_used[p])
      );
    end

    // Internal sources: optional synchronizer, active-high edge or level.
    for (genvar s = 0; s < INT_N; s++) begin : g_int
      logic cond;

      irq_sync_stage #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (src_raw[INT_LO + s]),
        .bypass (byp_q[s]),
        .dout   (cond)
      );

      irq_trigger_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond       (cond),
        .level_sel  (trig_q[s]),
        .rise_en    (1'b1),
        .fall_en    (1'b0),
        .level_high (1'b1),
        .clr        (clr_vec[INT_LO + s]),
        .pend       (pend_used[INT_LO + s])
      );
    end
  endgenerate

  // Readback and output assembly; reserved positions stay zero.
  always_comb begin
    trig_rd                = '0;
    trig_rd[INT_HI:INT_LO] = trig_q;
    sync_rd                = '0;
    sync_rd[INT_HI:INT_LO] = byp_q;
    pending                = '0;
    pending[USED-1:0]      = pend_used;
  end

  assign pmode_rd = pmode_q;

  logic unused_bits;
  assign unused_bits = ^{trig_wdata[SRC_W-1:USED], trig_wdata[EXT_N-1:0],
                         sync_wdata[SRC_W-1:USED], sync_wdata[EXT_N-1:0],
                         src_raw[SRC_W-1:USED], clr_vec[SRC_W-1:USED]};

  assert_trig_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trig_we) |-> (trig_rd == ($past(trig_wdata) & {{(SRC_W-USED){1'b0}}, {INT_N{1'b1}}, {EXT_N{1'b0}}})));

endmodule

// File: tb/irq_source_conditioner_test.sv
module irq_source_conditioner_test;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 32;
  localparam int NP = 4;
  localparam int NI = 15;
  localparam logic [SW-1:0] INT_MASK = 32'h0007_FFF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] src_raw = '0;
  logic          trig_we = 1'b0, sync_we = 1'b0, pmode_we = 1'b0, clr_we = 1'b0;
  logic [SW-1:0] trig_wdata = '0, sync_wdata = '0, clr_wdata = '0;
  logic [11:0]   pmode_wdata = '0;
  logic [SW-1:0] trig_rd, sync_rd, pending;
  logic [11:0]   pmode_rd;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_source_conditioner uut (
    .clk(clk), .rst_n(rst_n), .src_raw(src_raw),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .sync_we(sync_we), .sync_wdata(sync_wdata),
    .pmode_we(pmode_we), .pmode_wdata(pmode_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .trig_rd(trig_rd), .sync_rd(sync_rd), .pmode_rd(pmode_rd),
    .pending(pending)
  );

  task automatic check(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_trig(logic [SW-1:0] v);
    trig_we = 1'b1; trig_wdata = v; @(negedge clk); trig_we = 1'b0;
  endtask

  task automatic wr_sync(logic [SW-1:0] v);
    sync_we = 1'b1; sync_wdata = v; @(negedge clk); sync_we = 1'b0;
  endtask

  task automatic wr_mode(logic [11:0] v);
    pmode_we = 1'b1; pmode_wdata = v; @(negedge clk); pmode_we = 1'b0;
  endtask

  task automatic clear(logic [SW-1:0] v);
    clr_we = 1'b1; clr_wdata = v; @(negedge clk); clr_we = 1'b0; clr_wdata = '0;
  endtask

  // Expected-value helpers restated from the mode table.
  function automatic bit m_lvl(int c);  return (c % 4) == 3; endfunction
  function automatic bit m_high(int c); return c >= 4; endfunction
  function automatic bit m_rise(int c); return (c % 4) == 1 || (c % 4) == 2; endfunction
  function automatic bit m_fall(int c); return (c % 4) == 0 || (c % 4) == 2; endfunction
  function automatic bit m_filt(int c); return c < 4 || c == 7; endfunction

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    check("R1 pending", pending, '0);
    check("R1 trig", trig_rd, '0);
    check("R1 sync", sync_rd, '0);
    check("R1 pmode", {20'd0, pmode_rd}, '0);

    // R5 reserved storage and pending
    wr_trig('1);
    check("R5 trig readback", trig_rd, INT_MASK);
    wr_sync('1);
    check("R5 sync readback", sync_rd, INT_MASK);
    src_raw = 32'hFFF8_0000;
    wait_n(5);
    check("R5 reserved pending", pending, '0);
    src_raw = '0;
    wr_trig('0);
    wr_sync('0);
    wait_n(4);

    // R2/R3/R4 sweep over internal sources
    for (int i = NP; i < NP + NI; i++) begin
      logic [SW-1:0] b;
      b = SW'(1) << i;
      src_raw = b;
      wait_n(2);
      check("R2 sync not yet", pending, '0);
      wait_n(1);
      check("R2 sync latency", pending, b);
      src_raw = '0;
      wait_n(4);
      check("R3 edge sticky", pending, b);
      clear(~b);
      check("R4 clear other bits", pending, b);
      clear(b);
      check("R4 clear own bit", pending, '0);
      wr_sync(b);
      src_raw = b;
      wait_n(1);
      check("R2 bypass latency", pending, b);
      src_raw = '0;
      wait_n(1);
      clear(b);
      check("R4 clear after bypass", pending, '0);
      wr_sync('0);
      wait_n(3);
    end

    // R4 set and clear at the same edge: set wins
    wr_sync(32'h20);
    src_raw = 32'h20;
    wait_n(1);
    src_raw = '0;
    wait_n(1);
    src_raw = 32'h20;
    clear(32'h20);
    check("R4 edge beats clear", pending, 32'h20);
    src_raw = '0;
    wait_n(1);
    clear(32'h20);
    check("R4 cleared", pending, '0);

    // R3/R9 level mode on source 7
    wr_trig(32'h80);
    wr_sync(32'h80);
    src_raw = 32'h80;
    wait_n(1);
    check("R3 level follows high", pending, 32'h80);
    clear(32'h80);
    check("R9 level ignores clear", pending, 32'h80);
    src_raw = '0;
    wait_n(1);
    check("R3 level follows low", pending, '0);
    wr_trig('0);
    wr_sync('0);
    wait_n(3);

    // R6/R7/R8/R10 sweep over pins and mode codes
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 8; c++) begin
        logic [SW-1:0] b;
        logic [11:0]   mv;
        b  = SW'(1) << p;
        mv = 12'(c) << (3 * p);
        wr_mode(mv);
        check("R10 mode readback", {20'd0, pmode_rd}, {20'd0, mv});
        wait_n(12);
        clear(b);
        check("R8 idle level", pending, (m_lvl(c) && !m_high(c)) ? b : '0);
        src_raw = b;
        wait_n(12);
        check("R6 R8 after rise", pending, (m_lvl(c) ? m_high(c) : m_rise(c)) ? b : '0);
        clear(b);
        src_raw = '0;
        wait_n(12);
        check("R6 R8 after fall", pending, (m_lvl(c) ? !m_high(c) : m_fall(c)) ? b : '0);
        clear(b);
        for (int w = 1; w <= 3; w++) begin
          bit e;
          src_raw = b;
          wait_n(w);
          src_raw = '0;
          wait_n(12);
          if (m_lvl(c))        e = !m_high(c);
          else if (w == 3)     e = 1'b1;
          else                 e = !m_filt(c);
          check("R7 pulse filter", pending, e ? b : '0);
          clear(b);
        end
      end
      wr_mode('0);
      wait_n(12);
      clear('1);
    end

    check("R10 final quiet", pending, '0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule